// File: doc/BRIEF.md
# PHY Register Handshake Responder

This block is the PHY-side target of a strobe-and-acknowledge register port. A host drives a single 32-bit control word whose low half carries an address or data value and whose bits 16 to 19 carry four strobes. The responder keeps a small bank of 16-bit configuration registers. It records an address or a data value when the matching capture strobe is seen, and it performs a register write or a register read on the write and read strobes. Every strobe is answered with an acknowledge that stays up until the host withdraws the strobe.

The acknowledge and the last read value come back in a 32-bit status word. A parameter sets how many clock edges pass before the acknowledge rises, which lets a host's timeout path be exercised. A few register fields also leave the block as ports so that the surrounding PHY logic can act on them: a PLL multiplier override, a reference divider override and two receiver enable overrides.

Top module: `phy_reg_responder`

## Requirements
- R1: While reset is high and on the first cycle after it, the status word is zero and every override output is zero.
- R2: A strobe is one of control bits 16 (capture address), 17 (capture data), 18 (write) and 19 (read). When one is present in the control word, status bit 16 (ack) rises on the ACK_LAT-th rising clock edge, counting as the first the edge that first samples the strobe.
- R3: Ack stays high while the strobe is held. It falls on the first edge that samples all strobes low.
- R4: When ack rises for a capture-address strobe, control bits 15:0 become the register address. When ack rises for a capture-data strobe, control bits 15:0 become the write data.
- R5: A write strobe stores the captured data at the captured address once, on the edge where its ack rises. Control bits 15:0 present during the write strobe have no effect.
- R6: A read strobe loads the value at the captured address into status bits 15:0 on the edge where its ack rises. The value stays there until the next read.
- R7: At address 0x0011, bits 8:2 drive the 7-bit multiplier output and bit 9 drives its override enable. At address 0x0010, bit 0 drives the reference divider output and bit 2 drives its override enable. Reads return all 16 written bits.
- R8: At address 0x1005, bit 5 drives the receiver data-enable override output and bit 3 drives the receiver PLL-enable override output.
- R9: Address 0x100D is read-only and always reads 0x0001 (receiver output valid). Writes to it change nothing.
- R10: Reads of any other address return zero. Writes to any other address change no register and no output.
- R11: If a strobe is withdrawn before its ack rises, ack does not rise and the strobe has no effect.
- R12: A control word with any of bits 31:20 set is treated as carrying no strobe. Status bits 31:17 are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_word | input | 32 | Strobes in bits 19:16, address or data in bits 15:0 |
| stat_word | output | 32 | Ack in bit 16, read value in bits 15:0 |
| mpll_mult | output | 7 | PLL multiplier override value |
| mpll_mult_ovrd | output | 1 | PLL multiplier override enable |
| ref_div | output | 1 | Reference divider override value |
| ref_div_ovrd | output | 1 | Reference divider override enable |
| rx_data_en_ovrd | output | 1 | Receiver data-enable override |
| rx_pll_en_ovrd | output | 1 | Receiver PLL-enable override |

## Verification
The assertions assume that the host follows the handshake. The host raises one strobe at a time and holds it until ack appears or until it deliberately abandons the strobe. It changes the strobe bits only after ack has settled. The stimulus is built from one task that sets exactly one strobe bit, waits for ack, drops the strobe and waits for ack to fall. The only exceptions are the two deliberate cases: a strobe abandoned early, and a word with reserved bits set. These are driven by hand and are bounded in time.

// File: rtl/phyrsp_pkg.sv
package phyrsp_pkg;

    localparam int DATA_W   = 16;
    localparam int CTL_W    = 32;
    localparam int STB_LSB  = 16;
    localparam int STB_N    = 4;
    localparam int RSV_LSB  = STB_LSB + STB_N;
    localparam int NUM_RW   = 3;

    // strobe vector as it sits in control bits 19:16 (bit 16 is cap_adr)
    typedef struct packed {
        logic rd;
        logic wr;
        logic cap_dat;
        logic cap_adr;
    } strobe_t;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_ACK  = 2'd2
    } hs_state_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] idx;
    } decode_t;

    localparam logic [DATA_W-1:0] ADDR_REFCLK = 16'h0010;
    localparam logic [DATA_W-1:0] ADDR_MPLL   = 16'h0011;
    localparam logic [DATA_W-1:0] ADDR_RXOVR  = 16'h1005;
    localparam logic [DATA_W-1:0] ADDR_RXSTAT = 16'h100D;
    localparam logic [DATA_W-1:0] RXSTAT_VAL  = 16'h0001;

    localparam logic [1:0] IDX_REFCLK = 2'd0;
    localparam logic [1:0] IDX_MPLL   = 2'd1;
    localparam logic [1:0] IDX_RXOVR  = 2'd2;

    function automatic decode_t decode_rw(input logic [DATA_W-1:0] a);
        decode_t d;
        d.hit = 1'b1;
        d.idx = IDX_REFCLK;
        case (a)
            ADDR_REFCLK: d.idx = IDX_REFCLK;
            ADDR_MPLL:   d.idx = IDX_MPLL;
            ADDR_RXOVR:  d.idx = IDX_RXOVR;
            default:     d.hit = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/phyrsp_handshake.sv
module phyrsp_handshake
    import phyrsp_pkg::*;
#(
    parameter int ACK_LAT = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t stb,
    output logic    ack,
    output logic    fire
);
    localparam int CNT_W = (ACK_LAT < 2) ? 1 : $clog2(ACK_LAT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_LAT - 1);

    hs_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             any_stb;

    assign any_stb = |stb;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        case (st_q)
            HS_IDLE: begin
                if (any_stb) begin
                    if (ACK_LAT <= 1) begin
                        st_d = HS_ACK;
                        fire = 1'b1;
                    end else begin
                        st_d = HS_WAIT;
                    end
                end
            end
            HS_WAIT: begin
                if (!any_stb) begin
                    st_d = HS_IDLE;
                end else if (cnt_q == LAST) begin
                    st_d = HS_ACK;
                    fire = 1'b1;
                end
            end
            HS_ACK: begin
                if (!any_stb) st_d = HS_IDLE;
            end
            default: st_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= HS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == HS_IDLE && any_stb)
                cnt_q <= CNT_W'(1);
            else if (st_q == HS_WAIT)
                cnt_q <= cnt_q + CNT_W'(1);
            else
                cnt_q <= '0;
        end
    end

    assign ack = (st_q == HS_ACK);

    // R3: ack persists while the strobe is held
    p_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ack && any_stb) |=> ack);
    // R3: ack drops once the strobe is released
    p_ack_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (ack && !any_stb) |=> !ack);
    // R2, R11: ack only ever rises with a strobe present at that edge
    p_ack_needs_stb_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(any_stb));
    // R5: an action fires once per handshake
    p_single_fire_r5: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/phyrsp_regbank.sv
module phyrsp_regbank
    import phyrsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  strobe_t           stb,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic [6:0]        mpll_mult,
    output logic              mpll_mult_ovrd,
    output logic              ref_div,
    output logic              ref_div_ovrd,
    output logic              rx_data_en_ovrd,
    output logic              rx_pll_en_ovrd
);
    logic [DATA_W-1:0]             addr_q;
    logic [DATA_W-1:0]             wdat_q;
    logic [NUM_RW-1:0][DATA_W-1:0] regs_q;
    decode_t                       dec;
    logic [DATA_W-1:0]             rd_val;
    logic                          do_wr;

    assign dec   = decode_rw(addr_q);
    assign do_wr = fire && stb.wr && dec.hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            wdat_q <= '0;
        end else if (fire) begin
            if (stb.cap_adr) addr_q <= din;
            if (stb.cap_dat) wdat_q <= din;
        end
    end

    for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (do_wr && dec.idx == 2'(i))
                regs_q[i] <= wdat_q;
        end
    end

    always_comb begin
        if (dec.hit)
            rd_val = regs_q[dec.idx];
        else if (addr_q == ADDR_RXSTAT)
            rd_val = RXSTAT_VAL;
        else
            rd_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (fire && stb.rd)
            rdata <= rd_val;
    end

    assign mpll_mult       = regs_q[IDX_MPLL][8:2];
    assign mpll_mult_ovrd  = regs_q[IDX_MPLL][9];
    assign ref_div         = regs_q[IDX_REFCLK][0];
    assign ref_div_ovrd    = regs_q[IDX_REFCLK][2];
    assign rx_data_en_ovrd = regs_q[IDX_RXOVR][5];
    assign rx_pll_en_ovrd  = regs_q[IDX_RXOVR][3];

    // R9, R10: a write outside the writable set leaves the bank untouched
    p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (rst)
        (fire && stb.wr && !dec.hit) |=> $stable(regs_q));
    // R10: read of an unmapped address returns zero
    p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (rst)
        (fire && stb.rd && !dec.hit && addr_q != ADDR_RXSTAT) |=> (rdata == '0));
    // R6: read data only changes on a read action
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(fire && stb.rd) |=> $stable(rdata));
    // R4: captured address only changes on a capture-address action
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(fire && stb.cap_adr) |=> $stable(addr_q));

endmodule

// File: rtl/phy_reg_responder.sv
module phy_reg_responder
    import phyrsp_pkg::*;
#(
    parameter int ACK_LAT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ctl_word,
    output logic [31:0] stat_word,
    output logic [6:0]  mpll_mult,
    output logic        mpll_mult_ovrd,
    output logic        ref_div,
    output logic        ref_div_ovrd,
    output logic        rx_data_en_ovrd,
    output logic        rx_pll_en_ovrd
);
    strobe_t           stb;
    logic              ctl_ok;
    logic              ack;
    logic              fire;
    logic [DATA_W-1:0] rdata;

    initial begin
        if (ACK_LAT < 1) $error("ACK_LAT must be at least 1");
    end

    // reserved upper bits must be clear for the word to count
    assign ctl_ok = (ctl_word[CTL_W-1:RSV_LSB] == '0);
    assign stb    = ctl_ok ? strobe_t'(ctl_word[RSV_LSB-1:STB_LSB]) : '0;

    phyrsp_handshake #(.ACK_LAT(ACK_LAT)) u_hs (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb),
        .ack  (ack),
        .fire (fire)
    );

    phyrsp_regbank u_bank (
        .clk             (clk),
        .rst             (rst),
        .fire            (fire),
        .stb             (stb),
        .din             (ctl_word[DATA_W-1:0]),
        .rdata           (rdata),
        .mpll_mult       (mpll_mult),
        .mpll_mult_ovrd  (mpll_mult_ovrd),
        .ref_div         (ref_div),
        .ref_div_ovrd    (ref_div_ovrd),
        .rx_data_en_ovrd (rx_data_en_ovrd),
        .rx_pll_en_ovrd  (rx_pll_en_ovrd)
    );

    assign stat_word = {15'b0, ack, rdata};

    // R12: a word with reserved bits set never starts a handshake
    p_rsv_blocks_r12: assert property (@(posedge clk) disable iff (rst)
        (!ack && !ctl_ok) |=> !ack);

endmodule

// File: tb/sim_phy_reg_responder.sv
module sim_phy_reg_responder;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctl = '0;
    logic [31:0] stat;
    logic [6:0]  mult;
    logic        mult_ov, rdiv, rdiv_ov, rxd, rxp;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m10 = '0, m11 = '0, m1005 = '0;

    always #2 clk = ~clk;

    phy_reg_responder #(.ACK_LAT(LAT)) u0 (
        .clk(clk), .rst(rst), .ctl_word(ctl), .stat_word(stat),
        .mpll_mult(mult), .mpll_mult_ovrd(mult_ov), .ref_div(rdiv),
        .ref_div_ovrd(rdiv_ov), .rx_data_en_ovrd(rxd), .rx_pll_en_ovrd(rxp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_rd(input logic [15:0] a);
        case (a)
            16'h0010: return m10;
            16'h0011: return m11;
            16'h1005: return m1005;
            16'h100D: return 16'h0001;
            default:  return 16'h0000;
        endcase
    endfunction

    function automatic void model_wr(input logic [15:0] a, input logic [15:0] d);
        case (a)
            16'h0010: m10 = d;
            16'h0011: m11 = d;
            16'h1005: m1005 = d;
            default: ;
        endcase
    endfunction

    // one full handshake: bit s of the strobe field, payload d
    task automatic hs(input int s, input logic [15:0] d);
        int k;
        @(negedge clk);
        ctl = {12'h0, 4'(1 << s), d};
        k = 0;
        while (stat[16] !== 1'b1 && k < 50) begin
            @(negedge clk);
            k++;
        end
        check("R2 ack latency", k, LAT);
        @(negedge clk);
        @(negedge clk);
        check("R3 ack held", {31'b0, stat[16]}, 1);
        ctl = {16'h0, d};
        @(negedge clk);
        check("R3 ack fall", {31'b0, stat[16]}, 0);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        hs(0, a);
        hs(1, d);
        hs(2, ~d);   // R5: payload during write must be ignored
        model_wr(a, d);
    endtask

    task automatic do_read(input logic [15:0] a, output logic [15:0] v);
        hs(0, a);
        hs(3, 16'h0);
        v = stat[15:0];
    endtask

    task automatic check_outs(input string tag);
        check({tag, " R7 mult"},  {25'b0, mult},     {25'b0, m11[8:2]});
        check({tag, " R7 mov"},   {31'b0, mult_ov},  {31'b0, m11[9]});
        check({tag, " R7 div"},   {31'b0, rdiv},     {31'b0, m10[0]});
        check({tag, " R7 dov"},   {31'b0, rdiv_ov},  {31'b0, m10[2]});
        check({tag, " R8 rxd"},   {31'b0, rxd},      {31'b0, m1005[5]});
        check({tag, " R8 rxp"},   {31'b0, rxp},      {31'b0, m1005[3]});
    endtask

    initial begin : watchdog
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        logic [15:0] addrs [8] = '{16'h0010, 16'h0011, 16'h1005, 16'h100D,
                                   16'h0012, 16'h0000, 16'hFFFF, 16'h1004};
        logic [15:0] pats [5] = '{16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h0000, 16'h0228};

        repeat (3) @(negedge clk);
        check("R1 status in reset", stat, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status after reset", stat, 0);
        check_outs("R1");

        // sweep: every pattern to every address, read all mapped back
        foreach (pats[p]) begin
            foreach (addrs[i]) begin
                logic [15:0] d;
                d = pats[p] ^ addrs[i];
                do_write(addrs[i], d);
                do_read(addrs[i], v);
                check("R6 R9 R10 readback", {16'h0, v}, {16'h0, model_rd(addrs[i])});
                check("R12 status upper", {16'h0, stat[31:16]}, 0);
                check_outs("R7 R8");
                for (int j = 0; j < 3; j++) begin
                    do_read(addrs[j], v);
                    check("R10 mapped intact", {16'h0, v}, {16'h0, model_rd(addrs[j])});
                end
            end
        end

        // field-specific values
        do_write(16'h0011, 16'h0264);   // mult 25, override on
        check_outs("R7 mpll");
        do_write(16'h0010, 16'h0005);
        check_outs("R7 refclk");
        do_write(16'h1005, 16'h0028);
        check_outs("R8 rx");

        // R6: read value held across non-read handshakes
        do_read(16'h0011, v);
        hs(0, 16'h1005);
        hs(1, 16'h1234);
        check("R6 read held", {16'h0, stat[15:0]}, {16'h0, m11});

        // R11: capture-address abandoned before ack
        hs(0, 16'h0010);
        @(negedge clk);
        ctl = 32'h0001_0011;
        @(negedge clk);
        ctl = 32'h0000_0011;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R11 no ack", {31'b0, stat[16]}, 0);
        end
        hs(3, 16'h0);
        check("R11 address unchanged", {16'h0, stat[15:0]}, {16'h0, m10});

        // R12: reserved bit set blocks the handshake
        @(negedge clk);
        ctl = 32'h8001_0011;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check("R12 no ack", {31'b0, stat[16]}, 0);
        end
        ctl = 32'h0;
        @(negedge clk);
        hs(3, 16'h0);
        check("R12 address unchanged", {16'h0, stat[15:0]}, {16'h0, m10});

        // R9: write to read-only location leaves it at 0x0001
        do_write(16'h100D, 16'hFFFE);
        do_read(16'h100D, v);
        check("R9 read-only", {16'h0, v}, 32'h0001);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule